// File: doc/BRIEF.md
# Six-Valued Static-Hazard Evaluator

This block looks for static hazards in a small, fixed combinational network. It watches a stream of input vectors. Each accepted vector is paired with the vector accepted before it. For every network input, the pair is turned into a transition class. A class is a triple of three-valued logic: the old value, an uncertain middle instant, and the new value. The network's gates are then evaluated one component at a time on these triples. Each network output is reported as one of six classes: static 0, static 1, rise, fall, static-0 hazard or static-1 hazard.

The network is levelized. It is described by parameters: an operation code per gate (AND, OR, NOT, buffer), two source node indices per gate, and a node index per output. Nodes 0..N_IN-1 are the inputs. Node N_IN+g is the output of gate g, and a gate may only read nodes below its own. The default network has four inputs and two outputs, built from six gates. An output register presents one result per accepted vector, together with a flag that is raised whenever any output carries a hazard class.

Top module: `hazard_eval`

## Requirements
- R1: While reset is asserted, out_valid and hazard are 0 and out_cls is all zeros.
- R2: The first vector accepted (in_valid high at a rising clock edge) after reset produces no result. Every later accepted vector raises out_valid for exactly one cycle, directly after the edge that accepted it.
- R3: A cycle with in_valid low produces no result and does not change the stored vector. The next accepted vector is paired with the last accepted one, however many idle cycles lie between them.
- R4: An input bit whose value is the same in both vectors is encoded as static (triple 000 or 111). A bit going 0 to 1 is encoded as rise (0X1), and a bit going 1 to 0 as fall (1X0).
- R5: Each output class is a 3-bit code: 0 = static 0, 1 = static 1, 2 = rise, 3 = fall, 4 = static-0 hazard, 5 = static-1 hazard. No other code is ever presented with out_valid.
- R6: An AND gate works on each triple component separately. A 0 on either operand gives 0, 1 on both operands gives 1, and any other combination gives X.
- R7: An OR gate works on each component separately. A 1 on either operand gives 1, 0 on both operands gives 0, and any other combination gives X. A NOT gate swaps 0 and 1 and leaves X as X.
- R8: A result triple whose first and last components differ is a rise (0..1) or a fall (1..0). When they are equal, the result is static if the middle component equals them, and the matching hazard class if the middle is X.
- R9: hazard is 1 exactly when out_valid is 1 and at least one output code is 4 or 5. It is 0 in every cycle without a result.
- R10: With the default parameters, in_vec bits 0..3 are inputs a..d. Output 0 (out_cls[2:0]) is (a AND b) OR NOT(b OR c). Output 1 (out_cls[5:3]) is NOT(d AND NOT(b OR c)).
- R11: When two consecutive accepted vectors are identical, every output class in the resulting cycle is static 0 or static 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Qualifies in_vec for this cycle |
| in_vec | input | N_IN | Input vector, bit i drives network node i |
| out_valid | output | 1 | A result is present on out_cls and hazard |
| out_cls | output | 3*N_OUT | Class code per output, output k at bits [3k+2:3k] |
| hazard | output | 1 | Some output carries a static-0 or static-1 hazard class |

## Verification
A corrupted stored vector shows up on the very next result: the rise, fall and static classes are computed against the wrong old value. A stuck or mis-set pairing flag shows up one cycle after the first vector as a missing or extra out_valid. A wrong component rule in a gate produces a class code that differs from the arithmetic model the same cycle the affected pair is presented. Sweeping every ordered pair of the 16 input vectors back to back reaches every rule in the default network within a few hundred cycles.

// File: rtl/hz_pkg.sv
package hz_pkg;

  typedef enum logic [1:0] {
    TV0 = 2'b00,
    TV1 = 2'b01,
    TVX = 2'b10
  } tv_e;

  typedef struct packed {
    tv_e first;
    tv_e mid;
    tv_e last;
  } trip_t;

  localparam int CLS_W = 3;

  typedef enum logic [CLS_W-1:0] {
    C_S0   = 3'd0,
    C_S1   = 3'd1,
    C_RISE = 3'd2,
    C_FALL = 3'd3,
    C_H0   = 3'd4,
    C_H1   = 3'd5
  } cls_e;

  localparam int OP_W  = 2;
  localparam int IDX_W = 8;

  localparam logic [OP_W-1:0] OP_AND = 2'd0;
  localparam logic [OP_W-1:0] OP_OR  = 2'd1;
  localparam logic [OP_W-1:0] OP_NOT = 2'd2;
  localparam logic [OP_W-1:0] OP_BUF = 2'd3;

  function automatic tv_e tv_and(input tv_e a, input tv_e b);
    if (a == TV0 || b == TV0)      return TV0;
    else if (a == TV1 && b == TV1) return TV1;
    else                           return TVX;
  endfunction

  function automatic tv_e tv_or(input tv_e a, input tv_e b);
    if (a == TV1 || b == TV1)      return TV1;
    else if (a == TV0 && b == TV0) return TV0;
    else                           return TVX;
  endfunction

  function automatic tv_e tv_not(input tv_e a);
    if (a == TV0)      return TV1;
    else if (a == TV1) return TV0;
    else               return TVX;
  endfunction

  function automatic trip_t trip_gate(input logic [OP_W-1:0] op,
                                      input trip_t a, input trip_t b);
    trip_t r;
    case (op)
      OP_AND: begin
        r.first = tv_and(a.first, b.first);
        r.mid   = tv_and(a.mid,   b.mid);
        r.last  = tv_and(a.last,  b.last);
      end
      OP_OR: begin
        r.first = tv_or(a.first, b.first);
        r.mid   = tv_or(a.mid,   b.mid);
        r.last  = tv_or(a.last,  b.last);
      end
      OP_NOT: begin
        r.first = tv_not(a.first);
        r.mid   = tv_not(a.mid);
        r.last  = tv_not(a.last);
      end
      default: r = a;
    endcase
    return r;
  endfunction

  function automatic trip_t trip_of_bits(input logic old_b, input logic new_b);
    trip_t r;
    r.first = old_b ? TV1 : TV0;
    r.last  = new_b ? TV1 : TV0;
    r.mid   = (old_b == new_b) ? r.first : TVX;
    return r;
  endfunction

  function automatic cls_e cls_of_trip(input trip_t t);
    if (t.first != t.last)
      return (t.first == TV0) ? C_RISE : C_FALL;
    else if (t.first == TV0)
      return (t.mid == TV0) ? C_S0 : C_H0;
    else
      return (t.mid == TV1) ? C_S1 : C_H1;
  endfunction

endpackage

// File: rtl/hz_encoder.sv
module hz_encoder
  import hz_pkg::*;
#(
  parameter int N_IN = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [N_IN-1:0]   in_vec,
  output logic              fire,
  output trip_t [N_IN-1:0]  in_trip
);

  logic [N_IN-1:0] prev_q, prev_d;
  logic            have_q, have_d;
  logic            load_en;

  assign load_en = in_valid;

  always_comb begin
    prev_d = prev_q;
    have_d = have_q;
    if (load_en) begin
      prev_d = in_vec;
      have_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      have_q <= 1'b0;
    end else if (load_en) begin
      prev_q <= prev_d;
      have_q <= have_d;
    end
  end

  assign fire = in_valid && have_q;

  for (genvar i = 0; i < N_IN; i++) begin : g_enc
    assign in_trip[i] = trip_of_bits(prev_q[i], in_vec[i]);
  end

endmodule

// File: rtl/hz_network.sv
module hz_network
  import hz_pkg::*;
#(
  parameter int N_IN   = 4,
  parameter int N_GATE = 6,
  parameter int N_OUT  = 2,
  parameter logic [OP_W*N_GATE-1:0]  GATE_OP = '0,
  parameter logic [IDX_W*N_GATE-1:0] SRC_A   = '0,
  parameter logic [IDX_W*N_GATE-1:0] SRC_B   = '0,
  parameter logic [IDX_W*N_OUT-1:0]  OUT_SEL = '0
) (
  input  trip_t [N_IN-1:0]  in_trip,
  output trip_t [N_OUT-1:0] out_trip
);

  localparam int N_NODE = N_IN + N_GATE;

  trip_t [N_NODE-1:0] node;

  always_comb begin
    node = '0;
    for (int i = 0; i < N_IN; i++) begin
      node[i] = in_trip[i];
    end
    for (int g = 0; g < N_GATE; g++) begin
      node[N_IN+g] = trip_gate(GATE_OP[g*OP_W +: OP_W],
                               node[int'(SRC_A[g*IDX_W +: IDX_W])],
                               node[int'(SRC_B[g*IDX_W +: IDX_W])]);
    end
  end

  for (genvar k = 0; k < N_OUT; k++) begin : g_out
    assign out_trip[k] = node[int'(OUT_SEL[k*IDX_W +: IDX_W])];
  end

endmodule

// File: rtl/hz_outstage.sv
module hz_outstage
  import hz_pkg::*;
#(
  parameter int N_OUT = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    fire,
  input  trip_t [N_OUT-1:0]       out_trip,
  output logic                    out_valid,
  output logic [CLS_W*N_OUT-1:0]  out_cls,
  output logic                    hazard
);

  logic [CLS_W*N_OUT-1:0] cls_d, cls_q;
  logic [N_OUT-1:0]       haz_bits;
  logic                   valid_d, valid_q;
  logic                   haz_d, haz_q;

  for (genvar k = 0; k < N_OUT; k++) begin : g_cls
    cls_e c;
    assign c = cls_of_trip(out_trip[k]);
    assign cls_d[k*CLS_W +: CLS_W] = c;
    assign haz_bits[k] = (c == C_H0) || (c == C_H1);
  end

  always_comb begin
    valid_d = fire;
    haz_d   = fire && (|haz_bits);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      haz_q   <= 1'b0;
    end else begin
      valid_q <= valid_d;
      haz_q   <= haz_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cls_q <= '0;
    end else if (fire) begin
      cls_q <= cls_d;
    end
  end

  assign out_valid = valid_q;
  assign out_cls   = cls_q;
  assign hazard    = haz_q;

endmodule

// File: rtl/hazard_eval.sv
module hazard_eval
  import hz_pkg::*;
#(
  parameter int N_IN   = 4,
  parameter int N_GATE = 6,
  parameter int N_OUT  = 2,
  parameter logic [OP_W*N_GATE-1:0] GATE_OP =
    {OP_NOT, OP_AND, OP_OR, OP_NOT, OP_OR, OP_AND},
  parameter logic [IDX_W*N_GATE-1:0] SRC_A =
    {8'd8, 8'd3, 8'd4, 8'd5, 8'd1, 8'd0},
  parameter logic [IDX_W*N_GATE-1:0] SRC_B =
    {8'd0, 8'd6, 8'd6, 8'd0, 8'd2, 8'd1},
  parameter logic [IDX_W*N_OUT-1:0] OUT_SEL = {8'd9, 8'd7}
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  input  logic [N_IN-1:0]            in_vec,
  output logic                       out_valid,
  output logic [CLS_W*N_OUT-1:0]     out_cls,
  output logic                       hazard
);

  logic [1:0] rst_pipe;
  logic       rst_sync;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end

  assign rst_sync = rst_pipe[1];

  logic              fire;
  trip_t [N_IN-1:0]  in_trip;
  trip_t [N_OUT-1:0] out_trip;

  hz_encoder #(.N_IN(N_IN)) u_enc (
    .clk      (clk),
    .rst_n    (rst_sync),
    .in_valid (in_valid),
    .in_vec   (in_vec),
    .fire     (fire),
    .in_trip  (in_trip)
  );

  hz_network #(
    .N_IN    (N_IN),
    .N_GATE  (N_GATE),
    .N_OUT   (N_OUT),
    .GATE_OP (GATE_OP),
    .SRC_A   (SRC_A),
    .SRC_B   (SRC_B),
    .OUT_SEL (OUT_SEL)
  ) u_net (
    .in_trip  (in_trip),
    .out_trip (out_trip)
  );

  hz_outstage #(.N_OUT(N_OUT)) u_out (
    .clk       (clk),
    .rst_n     (rst_sync),
    .fire      (fire),
    .out_trip  (out_trip),
    .out_valid (out_valid),
    .out_cls   (out_cls),
    .hazard    (hazard)
  );

endmodule

// File: rtl/hazard_eval_chk.sv
module hazard_eval_chk #(
  parameter int N_IN  = 4,
  parameter int N_OUT = 2
) (
  input logic                 clk,
  input logic                 rst_sync,
  input logic                 in_valid,
  input logic [N_IN-1:0]      in_vec,
  input logic                 out_valid,
  input logic [3*N_OUT-1:0]   out_cls,
  input logic                 hazard
);

  logic            seen_q;
  logic [N_IN-1:0] last_q;
  logic            all_legal;
  logic            all_static;

  always_ff @(posedge clk or negedge rst_sync) begin
    if (!rst_sync) begin
      seen_q <= 1'b0;
      last_q <= '0;
    end else if (in_valid) begin
      seen_q <= 1'b1;
      last_q <= in_vec;
    end
  end

  always_comb begin
    all_legal  = 1'b1;
    all_static = 1'b1;
    for (int k = 0; k < N_OUT; k++) begin
      if (out_cls[k*3 +: 3] > 3'd5) all_legal  = 1'b0;
      if (out_cls[k*3 +: 3] > 3'd1) all_static = 1'b0;
    end
  end

  // R2: a result needs an accepted vector with an earlier one before it
  a_r2_result_has_pair: assert property (@(posedge clk) disable iff (!rst_sync)
    out_valid |-> ($past(in_valid) && $past(seen_q)));

  // R2: every paired vector yields a result
  a_r2_no_dropped_result: assert property (@(posedge clk) disable iff (!rst_sync)
    (in_valid && seen_q) |=> out_valid);

  // R5
  a_r5_legal_codes: assert property (@(posedge clk) disable iff (!rst_sync)
    out_valid |-> all_legal);

  // R9
  a_r9_hazard_needs_valid: assert property (@(posedge clk) disable iff (!rst_sync)
    hazard |-> out_valid);

  // R11
  a_r11_same_pair_static: assert property (@(posedge clk) disable iff (!rst_sync)
    (in_valid && seen_q && (in_vec == last_q)) |=> (out_valid && all_static));

endmodule

bind hazard_eval hazard_eval_chk #(.N_IN(N_IN), .N_OUT(N_OUT)) u_chk (
  .clk       (clk),
  .rst_sync  (rst_sync),
  .in_valid  (in_valid),
  .in_vec    (in_vec),
  .out_valid (out_valid),
  .out_cls   (out_cls),
  .hazard    (hazard)
);

// File: tb/test_hazard_eval.sv
module test_hazard_eval;

  logic       clk;
  logic       rst_n;
  logic       in_valid;
  logic [3:0] in_vec;
  logic       out_valid;
  logic [5:0] out_cls;
  logic       hazard;

  int compared;
  int mismatched;
  bit done;
  bit have_prev;
  logic [3:0] prev_v;

  hazard_eval i_hazard_eval (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_vec    (in_vec),
    .out_valid (out_valid),
    .out_cls   (out_cls),
    .hazard    (hazard)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Component model: per component a pair {may_be_1, may_be_0}.
  function automatic logic [5:0] m_enc(input logic p, input logic c);
    logic [1:0] e0, e2, m;
    e0 = p ? 2'b10 : 2'b01;
    e2 = c ? 2'b10 : 2'b01;
    m  = (p == c) ? e0 : 2'b11;
    return {e2, m, e0};
  endfunction

  function automatic logic [5:0] m_and(input logic [5:0] x, input logic [5:0] y);
    logic [5:0] r;
    for (int k = 0; k < 3; k++) begin
      r[2*k+1] = x[2*k+1] & y[2*k+1];
      r[2*k]   = x[2*k]   | y[2*k];
    end
    return r;
  endfunction

  function automatic logic [5:0] m_or(input logic [5:0] x, input logic [5:0] y);
    logic [5:0] r;
    for (int k = 0; k < 3; k++) begin
      r[2*k+1] = x[2*k+1] | y[2*k+1];
      r[2*k]   = x[2*k]   & y[2*k];
    end
    return r;
  endfunction

  function automatic logic [5:0] m_not(input logic [5:0] x);
    return {x[4], x[5], x[2], x[3], x[0], x[1]};
  endfunction

  function automatic logic [2:0] m_cls(input logic [5:0] x);
    logic [1:0] e0, m, e2;
    e0 = x[1:0]; m = x[3:2]; e2 = x[5:4];
    if (e0 != e2)       return (e0 == 2'b01) ? 3'd2 : 3'd3;
    else if (e0 == 2'b01) return (m == 2'b01) ? 3'd0 : 3'd4;
    else                return (m == 2'b10) ? 3'd1 : 3'd5;
  endfunction

  // R10 default network
  function automatic logic [5:0] m_net(input logic [3:0] p, input logic [3:0] c);
    logic [5:0] a, b, cc, d, e, f, g, h;
    a  = m_enc(p[0], c[0]);
    b  = m_enc(p[1], c[1]);
    cc = m_enc(p[2], c[2]);
    d  = m_enc(p[3], c[3]);
    e  = m_and(a, b);
    f  = m_not(m_or(b, cc));
    g  = m_or(e, f);
    h  = m_not(m_and(d, f));
    return {m_cls(h), m_cls(g)};
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [3:0] v);
    logic [5:0] ec;
    logic       eh;
    @(negedge clk);
    in_valid = 1'b1;
    in_vec   = v;
    @(posedge clk);
    #1;
    in_valid = 1'b0;
    if (!have_prev) begin
      check("R2 first vector no result", {7'd0, out_valid}, 8'd0);
    end else begin
      ec = m_net(prev_v, v);
      eh = (ec[2:0] >= 3'd4) || (ec[5:3] >= 3'd4);
      check("R2 result valid", {7'd0, out_valid}, 8'd1);
      check("R4/R5/R6/R7/R8/R10 out0", {5'd0, out_cls[2:0]}, {5'd0, ec[2:0]});
      check("R4/R5/R6/R7/R8/R10 out1", {5'd0, out_cls[5:3]}, {5'd0, ec[5:3]});
      check("R9 hazard flag", {7'd0, hazard}, {7'd0, eh});
      if (prev_v == v)
        check("R11 identical pair static", {7'd0, (out_cls[2:0] < 3'd2) && (out_cls[5:3] < 3'd2)}, 8'd1);
    end
    have_prev = 1'b1;
    prev_v    = v;
  endtask

  task automatic idle_check(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
      check("R3 idle no result", {6'd0, out_valid, hazard}, 8'd0);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1 reset valid/hazard", {6'd0, out_valid, hazard}, 8'd0);
    check("R1 reset classes", {2'd0, out_cls}, 8'd0);
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    have_prev = 1'b0;
  endtask

  initial begin
    compared = 0; mismatched = 0; done = 1'b0;
    have_prev = 1'b0; prev_v = '0;
    in_valid = 1'b0; in_vec = '0;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check("R1 reset valid/hazard", {6'd0, out_valid, hazard}, 8'd0);
    check("R1 reset classes", {2'd0, out_cls}, 8'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // all ordered pairs, back to back
    for (int p = 0; p < 256; p++) begin
      send(p[7:4]);
      send(p[3:0]);
    end

    // idle gap keeps stored vector
    send(4'b0110);
    idle_check(3);
    send(4'b1011);
    idle_check(1);
    send(4'b1011);

    // directed hazards: b falls with a=1,c=0 -> out0 gets static-1 hazard
    send(4'b0011);
    send(4'b0001);

    // reset mid-stream, then first vector again gives nothing
    do_reset();
    send(4'b1111);
    send(4'b0000);
    send(4'b0101);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule